// File: doc/BRIEF.md
# Chunk-Ordered Scratchpad Update Scheduler

This block holds a pool of in-flight scratchpads, one per candidate guess. Each scratchpad carries a tag for the data chunk it waits on, a guess identifier, a count of the work steps applied so far, and the hash it should finish with. A stream of chunk data arrives in a fixed, repeating order of chunk indices. When the last beat of a chunk is accepted, every scratchpad in the pool that waits on that chunk is sent, one per cycle, through a pipelined keyed mixing engine. The key is derived from the chunk's beats. While these scratchpads are sent, the chunk stream is held off.

Each scratchpad that leaves the pipeline has its step count raised by one. If the count has not reached the configured total, the scratchpad is forwarded so that it can be routed to whichever owner holds its next chunk. The next chunk index is taken from its own low bits. If the count has reached the total, the guess is retired, and a flag tells whether the final scratchpad matches the expected hash. The work is therefore ordered by the chunk that is streaming, not by guess.

Top module: `chunk_sched`

## Requirements
- R1: After reset, neither output valid (`fwd_valid_o`, `done_valid_o`) is asserted, both `chunk_ready_o` and `ins_ready_o` are high, the pool is empty and the current chunk index is 0.
- R2: A chunk consists of BEATS accepted beats. The current chunk index changes only on the accepted last beat of a chunk. It then steps by one and wraps from NUM_CHUNKS-1 to 0.
- R3: The pool holds DEPTH scratchpads. `ins_ready_o` is low exactly when all DEPTH slots are occupied. An insert offered while it is low is dropped, and every insert accepted while it is high adds exactly one entry.
- R4: On an accepted last beat, exactly the pool entries whose chunk tag equals that chunk's index are updated and leave the pool. All other entries stay in the pool untouched.
- R5: After an accepted last beat that selects N entries, `chunk_ready_o` stays low for exactly N cycles, one entry being issued per cycle. When N is 0 it does not drop at all.
- R6: The chunk key is the XOR of all beats of the chunk. The update applies PIPE rounds of the step "rotate the scratchpad left by one bit, then XOR with the key repeated across the full scratchpad width".
- R7: An updated scratchpad whose raised count is not TOTAL_WU appears on the forward port for one cycle. It carries the new count, its guess identifier and its expected hash unchanged, and `fwd_chunk_o` holds the low log2(NUM_CHUNKS) bits of the updated scratchpad (its index modulo NUM_CHUNKS).
- R8: An updated scratchpad whose raised count equals TOTAL_WU is not forwarded. It appears on the done port for one cycle with its guess identifier, and `done_match_o` is 1 exactly when the low HASH_W bits of the updated scratchpad equal its expected hash.
- R9: Within any one cycle, at most one of `fwd_valid_o` and `done_valid_o` is high, and each updated scratchpad produces exactly one such output pulse.
- R10: An entry inserted for a chunk after that chunk's last beat has been accepted is not included in that pass. It is updated on the next pass of the same chunk index, using the key of that later pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chunk_valid_i | input | 1 | Chunk beat offered |
| chunk_ready_o | output | 1 | Chunk beat can be accepted |
| chunk_data_i | input | KEY_W | Chunk beat data |
| ins_valid_i | input | 1 | Scratchpad insert offered |
| ins_ready_o | output | 1 | Pool has a free slot |
| ins_chunk_i | input | log2(NUM_CHUNKS) | Chunk the inserted entry waits on |
| ins_gid_i | input | GID_W | Guess identifier |
| ins_cnt_i | input | CNT_W | Work steps applied so far |
| ins_exp_i | input | HASH_W | Expected final hash |
| ins_sp_i | input | SP_W | Scratchpad contents |
| fwd_valid_o | output | 1 | Forwarded scratchpad valid (one cycle) |
| fwd_chunk_o | output | log2(NUM_CHUNKS) | Next chunk index for routing |
| fwd_gid_o | output | GID_W | Guess identifier |
| fwd_cnt_o | output | CNT_W | Raised step count |
| fwd_exp_o | output | HASH_W | Expected final hash |
| fwd_sp_o | output | SP_W | Updated scratchpad |
| done_valid_o | output | 1 | Retired guess valid (one cycle) |
| done_gid_o | output | GID_W | Retired guess identifier |
| done_match_o | output | 1 | Final scratchpad matched expected hash |

## Verification
On every cycle, the in-module properties check several things. The chunk index holds except on an accepted last beat. Every slot taken from the pool is occupied and carries the chunk being drained. Pool occupancy follows inserts and removals one for one. An empty pass never lowers the stream ready, and the forward and done outputs never fire together. Only the bench's scenarios can show the rest: the values that come out of the mixing pipeline, the count and routing bits on forwarded entries, the match flag on retired guesses, the wrap of the chunk order, inserts dropped while the pool is full, and the deferral of an entry inserted after its chunk's pass has begun.

// File: rtl/cs_pkg.sv
package cs_pkg;
    typedef enum logic {
        ST_STREAM = 1'b0,
        ST_ISSUE  = 1'b1
    } sched_state_e;
endpackage

// File: rtl/cs_mix_stage.sv
// One round of the keyed mixing pipeline: rotate left by one, XOR replicated key.
module cs_mix_stage #(
    parameter int SP_W   = 512,
    parameter int KEY_W  = 64,
    parameter int META_W = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [KEY_W-1:0]  in_key_i,
    input  logic [SP_W-1:0]   in_sp_i,
    input  logic [META_W-1:0] in_meta_i,
    output logic              out_valid_o,
    output logic [KEY_W-1:0]  out_key_o,
    output logic [SP_W-1:0]   out_sp_o,
    output logic [META_W-1:0] out_meta_o
);
    localparam int REP = SP_W / KEY_W;

    typedef struct packed {
        logic              vld;
        logic [KEY_W-1:0]  key;
        logic [SP_W-1:0]   sp;
        logic [META_W-1:0] meta;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d.vld  = in_valid_i;
        s_d.key  = in_key_i;
        s_d.meta = in_meta_i;
        s_d.sp   = {in_sp_i[SP_W-2:0], in_sp_i[SP_W-1]} ^ {REP{in_key_i}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid_o = s_q.vld;
    assign out_key_o   = s_q.key;
    assign out_sp_o    = s_q.sp;
    assign out_meta_o  = s_q.meta;
endmodule

// File: rtl/cs_pool.sv
// Tagged waiting pool: insert into the lowest free slot, remove by index.
module cs_pool #(
    parameter int DEPTH  = 16,
    parameter int SP_W   = 512,
    parameter int CIDX_W = 12,
    parameter int GID_W  = 8,
    parameter int CNT_W  = 8,
    parameter int HASH_W = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid_i,
    output logic              ins_ready_o,
    input  logic [CIDX_W-1:0] ins_chunk_i,
    input  logic [GID_W-1:0]  ins_gid_i,
    input  logic [CNT_W-1:0]  ins_cnt_i,
    input  logic [HASH_W-1:0] ins_exp_i,
    input  logic [SP_W-1:0]   ins_sp_i,
    input  logic [CIDX_W-1:0] cur_chunk_i,
    output logic [DEPTH-1:0]  match_o,
    input  logic              take_i,
    input  logic [IDX_W-1:0]  take_idx_i,
    output logic [CIDX_W-1:0] rd_chunk_o,
    output logic [GID_W-1:0]  rd_gid_o,
    output logic [CNT_W-1:0]  rd_cnt_o,
    output logic [HASH_W-1:0] rd_exp_o,
    output logic [SP_W-1:0]   rd_sp_o
);
    typedef struct packed {
        logic              vld;
        logic [CIDX_W-1:0] chunk;
        logic [GID_W-1:0]  gid;
        logic [CNT_W-1:0]  cnt;
        logic [HASH_W-1:0] exp;
        logic [SP_W-1:0]   sp;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
    } pool_t;

    pool_t            p_d, p_q;
    logic [DEPTH-1:0] vld_vec;
    logic [IDX_W-1:0] free_idx;
    logic             ins_fire;

    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            vld_vec[i] = p_q.ent[i].vld;
            match_o[i] = p_q.ent[i].vld && (p_q.ent[i].chunk == cur_chunk_i);
            if (!p_q.ent[i].vld) free_idx = IDX_W'(i);
        end
        ins_ready_o = ~&vld_vec;
        ins_fire    = ins_valid_i && ins_ready_o;

        p_d = p_q;
        if (take_i) p_d.ent[take_idx_i].vld = 1'b0;
        if (ins_fire) begin
            p_d.ent[free_idx].vld   = 1'b1;
            p_d.ent[free_idx].chunk = ins_chunk_i;
            p_d.ent[free_idx].gid   = ins_gid_i;
            p_d.ent[free_idx].cnt   = ins_cnt_i;
            p_d.ent[free_idx].exp   = ins_exp_i;
            p_d.ent[free_idx].sp    = ins_sp_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign rd_chunk_o = p_q.ent[take_idx_i].chunk;
    assign rd_gid_o   = p_q.ent[take_idx_i].gid;
    assign rd_cnt_o   = p_q.ent[take_idx_i].cnt;
    assign rd_exp_o   = p_q.ent[take_idx_i].exp;
    assign rd_sp_o    = p_q.ent[take_idx_i].sp;

    // R3: occupancy moves by exactly one per accepted insert, less any removal
    assert_fill_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ins_fire |=> $countones(vld_vec) ==
                     $past($countones(vld_vec)) + ($past(take_i) ? 0 : 1));

    // R4: a removal only ever targets an occupied slot
    assert_take_occupied_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> vld_vec[take_idx_i]);
endmodule

// File: rtl/chunk_sched.sv
module chunk_sched #(
    parameter int NUM_CHUNKS = 4096,
    parameter int BEATS      = 4,
    parameter int KEY_W      = 64,
    parameter int SP_W       = 512,
    parameter int GID_W      = 8,
    parameter int CNT_W      = 8,
    parameter int HASH_W     = 64,
    parameter int DEPTH      = 16,
    parameter int PIPE       = 6,
    parameter int TOTAL_WU   = 8,
    localparam int CIDX_W = $clog2(NUM_CHUNKS),
    localparam int BCNT_W = $clog2(BEATS + 1),
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int META_W = GID_W + CNT_W + HASH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chunk_valid_i,
    output logic              chunk_ready_o,
    input  logic [KEY_W-1:0]  chunk_data_i,
    input  logic              ins_valid_i,
    output logic              ins_ready_o,
    input  logic [CIDX_W-1:0] ins_chunk_i,
    input  logic [GID_W-1:0]  ins_gid_i,
    input  logic [CNT_W-1:0]  ins_cnt_i,
    input  logic [HASH_W-1:0] ins_exp_i,
    input  logic [SP_W-1:0]   ins_sp_i,
    output logic              fwd_valid_o,
    output logic [CIDX_W-1:0] fwd_chunk_o,
    output logic [GID_W-1:0]  fwd_gid_o,
    output logic [CNT_W-1:0]  fwd_cnt_o,
    output logic [HASH_W-1:0] fwd_exp_o,
    output logic [SP_W-1:0]   fwd_sp_o,
    output logic              done_valid_o,
    output logic [GID_W-1:0]  done_gid_o,
    output logic              done_match_o
);
    import cs_pkg::*;

    typedef struct packed {
        sched_state_e      st;
        logic [CIDX_W-1:0] cur;
        logic [CIDX_W-1:0] proc;
        logic [BCNT_W-1:0] beat;
        logic [KEY_W-1:0]  acc;
        logic [KEY_W-1:0]  key;
        logic [DEPTH-1:0]  pend;
        logic              fwd_v;
        logic [CIDX_W-1:0] fwd_c;
        logic [GID_W-1:0]  fwd_g;
        logic [CNT_W-1:0]  fwd_n;
        logic [HASH_W-1:0] fwd_e;
        logic [SP_W-1:0]   fwd_s;
        logic              done_v;
        logic [GID_W-1:0]  done_g;
        logic              done_m;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              beat_fire, last_beat, issue;
    logic [IDX_W-1:0]  pick_idx;
    logic [DEPTH-1:0]  match;
    logic [CIDX_W-1:0] rd_chunk;
    logic [GID_W-1:0]  rd_gid;
    logic [CNT_W-1:0]  rd_cnt;
    logic [HASH_W-1:0] rd_exp;
    logic [SP_W-1:0]   rd_sp;

    logic              st_vld  [0:PIPE];
    logic [KEY_W-1:0]  st_key  [0:PIPE];
    logic [SP_W-1:0]   st_sp   [0:PIPE];
    logic [META_W-1:0] st_meta [0:PIPE];

    logic [GID_W-1:0]  t_gid;
    logic [CNT_W-1:0]  t_cnt;
    logic [HASH_W-1:0] t_exp;

    cs_pool #(
        .DEPTH(DEPTH), .SP_W(SP_W), .CIDX_W(CIDX_W),
        .GID_W(GID_W), .CNT_W(CNT_W), .HASH_W(HASH_W)
    ) u_pool (
        .clk(clk), .rst_n(rst_n),
        .ins_valid_i(ins_valid_i), .ins_ready_o(ins_ready_o),
        .ins_chunk_i(ins_chunk_i), .ins_gid_i(ins_gid_i), .ins_cnt_i(ins_cnt_i),
        .ins_exp_i(ins_exp_i), .ins_sp_i(ins_sp_i),
        .cur_chunk_i(c_q.cur), .match_o(match),
        .take_i(issue), .take_idx_i(pick_idx),
        .rd_chunk_o(rd_chunk), .rd_gid_o(rd_gid), .rd_cnt_o(rd_cnt),
        .rd_exp_o(rd_exp), .rd_sp_o(rd_sp)
    );

    assign st_vld[0]  = issue;
    assign st_key[0]  = c_q.key;
    assign st_sp[0]   = rd_sp;
    assign st_meta[0] = {rd_gid, rd_cnt, rd_exp};

    for (genvar g = 0; g < PIPE; g++) begin : g_round
        cs_mix_stage #(.SP_W(SP_W), .KEY_W(KEY_W), .META_W(META_W)) u_stage (
            .clk(clk), .rst_n(rst_n),
            .in_valid_i(st_vld[g]), .in_key_i(st_key[g]),
            .in_sp_i(st_sp[g]), .in_meta_i(st_meta[g]),
            .out_valid_o(st_vld[g+1]), .out_key_o(st_key[g+1]),
            .out_sp_o(st_sp[g+1]), .out_meta_o(st_meta[g+1])
        );
    end

    assign t_gid = st_meta[PIPE][META_W-1 -: GID_W];
    assign t_cnt = st_meta[PIPE][HASH_W +: CNT_W];
    assign t_exp = st_meta[PIPE][HASH_W-1:0];

    always_comb begin
        pick_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (c_q.pend[i]) pick_idx = IDX_W'(i);
        end
        chunk_ready_o = (c_q.st == ST_STREAM);
        issue         = (c_q.st == ST_ISSUE);
        beat_fire     = chunk_valid_i && chunk_ready_o;
        last_beat     = (c_q.beat == BCNT_W'(BEATS - 1));

        c_d = c_q;
        if (beat_fire) begin
            if (last_beat) begin
                c_d.beat = '0;
                c_d.acc  = '0;
                c_d.key  = c_q.acc ^ chunk_data_i;
                c_d.proc = c_q.cur;
                c_d.cur  = (c_q.cur == CIDX_W'(NUM_CHUNKS - 1)) ? '0 : c_q.cur + 1'b1;
                c_d.pend = match;
                c_d.st   = (|match) ? ST_ISSUE : ST_STREAM;
            end else begin
                c_d.beat = c_q.beat + 1'b1;
                c_d.acc  = c_q.acc ^ chunk_data_i;
            end
        end
        if (issue) begin
            c_d.pend[pick_idx] = 1'b0;
            if (c_d.pend == '0) c_d.st = ST_STREAM;
        end

        c_d.fwd_v  = 1'b0;
        c_d.done_v = 1'b0;
        if (st_vld[PIPE]) begin
            if (t_cnt + 1'b1 == CNT_W'(TOTAL_WU)) begin
                c_d.done_v = 1'b1;
                c_d.done_g = t_gid;
                c_d.done_m = (st_sp[PIPE][HASH_W-1:0] == t_exp);
            end else begin
                c_d.fwd_v = 1'b1;
                c_d.fwd_c = st_sp[PIPE][CIDX_W-1:0];
                c_d.fwd_g = t_gid;
                c_d.fwd_n = t_cnt + 1'b1;
                c_d.fwd_e = t_exp;
                c_d.fwd_s = st_sp[PIPE];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign fwd_valid_o  = c_q.fwd_v;
    assign fwd_chunk_o  = c_q.fwd_c;
    assign fwd_gid_o    = c_q.fwd_g;
    assign fwd_cnt_o    = c_q.fwd_n;
    assign fwd_exp_o    = c_q.fwd_e;
    assign fwd_sp_o     = c_q.fwd_s;
    assign done_valid_o = c_q.done_v;
    assign done_gid_o   = c_q.done_g;
    assign done_match_o = c_q.done_m;

    // R2: the chunk index holds unless a last beat was accepted
    assert_cur_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(beat_fire && last_beat) |=> $stable(c_q.cur));

    // R4: every issued entry belongs to the chunk being drained
    assert_issue_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (rd_chunk == c_q.proc));

    // R5: a pass that selects nothing keeps the stream open
    assert_empty_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && last_beat && (match == '0)) |=> chunk_ready_o);

    // R9: forward and retire never coincide
    assert_one_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_valid_o, done_valid_o}));
endmodule

// File: tb/chunk_sched_bench.sv
module chunk_sched_bench;
    localparam int NC = 4, BT = 2, KW = 32, SW = 128, GW = 8, CW = 4;
    localparam int HW = 32, DP = 4, PP = 6, TW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          chunk_valid = 1'b0, chunk_ready;
    logic [KW-1:0] chunk_data = '0;
    logic          ins_valid = 1'b0, ins_ready;
    logic [1:0]    ins_chunk = '0;
    logic [GW-1:0] ins_gid = '0;
    logic [CW-1:0] ins_cnt = '0;
    logic [HW-1:0] ins_exp = '0;
    logic [SW-1:0] ins_sp = '0;
    logic          fwd_valid, done_valid, done_match;
    logic [1:0]    fwd_chunk;
    logic [GW-1:0] fwd_gid, done_gid;
    logic [CW-1:0] fwd_cnt;
    logic [HW-1:0] fwd_exp;
    logic [SW-1:0] fwd_sp;

    chunk_sched #(.NUM_CHUNKS(NC), .BEATS(BT), .KEY_W(KW), .SP_W(SW), .GID_W(GW),
                  .CNT_W(CW), .HASH_W(HW), .DEPTH(DP), .PIPE(PP), .TOTAL_WU(TW)) u_chunk_sched (
        .clk(clk), .rst_n(rst_n),
        .chunk_valid_i(chunk_valid), .chunk_ready_o(chunk_ready), .chunk_data_i(chunk_data),
        .ins_valid_i(ins_valid), .ins_ready_o(ins_ready), .ins_chunk_i(ins_chunk),
        .ins_gid_i(ins_gid), .ins_cnt_i(ins_cnt), .ins_exp_i(ins_exp), .ins_sp_i(ins_sp),
        .fwd_valid_o(fwd_valid), .fwd_chunk_o(fwd_chunk), .fwd_gid_o(fwd_gid),
        .fwd_cnt_o(fwd_cnt), .fwd_exp_o(fwd_exp), .fwd_sp_o(fwd_sp),
        .done_valid_o(done_valid), .done_gid_o(done_gid), .done_match_o(done_match));

    typedef struct packed {
        logic [1:0]    tag;
        logic [CW-1:0] cnt;
        logic          want;
        logic [SW-1:0] sp;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'd0, 4'd0, 1'b0, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210},
        '{2'd2, 4'd2, 1'b1, 128'hdead_beef_0000_1111_2222_3333_4444_5555},
        '{2'd3, 4'd2, 1'b0, 128'h8000_0000_0000_0000_0000_0000_0000_0001},
        '{2'd1, 4'd1, 1'b0, 128'h5a5a_a5a5_0f0f_f0f0_1234_5678_9abc_def0}
    };

    int n_chk = 0, n_fail = 0, ncs = 0, cur_b = 0;
    int nf = 0, nd = 0;
    logic [SW-1:0] cap_sp [16];
    logic [GW-1:0] cap_gid [16];
    logic [CW-1:0] cap_cnt [16];
    logic [1:0]    cap_ch [16];
    logic [HW-1:0] cap_exp [16];
    logic [GW-1:0] cap_dgid [16];
    logic          cap_dm [16];

    function automatic logic [KW-1:0] beat_data(int n);
        return (32'h9E37_79B9 * 32'(n + 1)) ^ 32'h5BD1_E995;
    endfunction

    function automatic logic [KW-1:0] key_of(int chunk_no);
        logic [KW-1:0] x = '0;
        for (int j = 0; j < BT; j++) x ^= beat_data(chunk_no * BT + j);
        return x;
    endfunction

    function automatic logic [SW-1:0] mix_model(logic [SW-1:0] s, logic [KW-1:0] k);
        for (int r = 0; r < PP; r++) s = {s[SW-2:0], s[SW-1]} ^ {(SW/KW){k}};
        return s;
    endfunction

    task automatic check(bit ok, string req, logic [SW-1:0] act, logic [SW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (fwd_valid && done_valid) begin
                n_fail++;
                $display("FAIL R9 actual both outputs valid expected at most one");
            end
            if (fwd_valid && nf < 16) begin
                cap_sp[nf] = fwd_sp; cap_gid[nf] = fwd_gid; cap_cnt[nf] = fwd_cnt;
                cap_ch[nf] = fwd_chunk; cap_exp[nf] = fwd_exp; nf++;
            end
            if (done_valid && nd < 16) begin
                cap_dgid[nd] = done_gid; cap_dm[nd] = done_match; nd++;
            end
        end
    end

    task automatic insert(int tag, int gid, int cnt, logic [HW-1:0] e, logic [SW-1:0] s);
        @(negedge clk);
        while (!ins_ready) @(negedge clk);
        ins_valid = 1'b1; ins_chunk = 2'(tag); ins_gid = GW'(gid);
        ins_cnt = CW'(cnt); ins_exp = e; ins_sp = s;
        @(posedge clk);
        #1 ins_valid = 1'b0;
    endtask

    task automatic send_chunk();
        for (int b = 0; b < BT; b++) begin
            @(negedge clk);
            while (!chunk_ready) @(negedge clk);
            chunk_valid = 1'b1;
            chunk_data = beat_data(ncs * BT + b);
            @(posedge clk);
            #1 chunk_valid = 1'b0;
        end
        ncs++;
        cur_b = (cur_b + 1) % NC;
    endtask

    task automatic drain_count(output int n);
        n = 0;
        @(negedge clk);
        while (!chunk_ready) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic settle();
        repeat (PP + 4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual hung expected completion");
        finish_run();
    end

    initial begin
        int n, steps, cno, tag;
        logic [SW-1:0] m, s21;
        logic [HW-1:0] e;
        logic [KW-1:0] k;
        bit ok;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(chunk_ready && ins_ready, "R1 ready after reset", {126'd0, chunk_ready, ins_ready}, 128'd3);
        check(!fwd_valid && !done_valid, "R1 outputs idle", {126'd0, fwd_valid, done_valid}, 128'd0);

        // Table walk: each vector waits on one chunk; the chunk order wraps (R2)
        for (int v = 0; v < 4; v++) begin
            tag = int'(VECS[v].tag);
            steps = (tag - cur_b + NC) % NC;
            cno = ncs + steps;
            k = key_of(cno);
            m = mix_model(VECS[v].sp, k);
            e = VECS[v].want ? m[HW-1:0] : (m[HW-1:0] ^ 32'h1);
            insert(tag, v, int'(VECS[v].cnt), e, VECS[v].sp);
            nf = 0; nd = 0;
            for (int s = 0; s <= steps; s++) begin
                send_chunk();
                drain_count(n);
                // R2/R4/R5: only the tagged chunk selects the entry
                check(n == ((s == steps) ? 1 : 0), "R5 ready-low cycles", SW'(n), SW'((s == steps) ? 1 : 0));
            end
            settle();
            if (int'(VECS[v].cnt) + 1 == TW) begin
                check(nd == 1 && nf == 0, "R8 retired not forwarded", SW'(nd * 16 + nf), SW'(16));
                check(cap_dgid[0] == GW'(v), "R8 done gid", SW'(cap_dgid[0]), SW'(v));
                check(cap_dm[0] == VECS[v].want, "R8 match flag", SW'(cap_dm[0]), SW'(VECS[v].want));
            end else begin
                check(nf == 1 && nd == 0, "R7 forwarded once", SW'(nf * 16 + nd), SW'(16));
                check(cap_sp[0] == m, "R6 mixed scratchpad", cap_sp[0], m);
                check(cap_cnt[0] == VECS[v].cnt + 1'b1, "R7 count raised", SW'(cap_cnt[0]), SW'(VECS[v].cnt + 1));
                check(cap_ch[0] == m[1:0], "R7 next chunk bits", SW'(cap_ch[0]), SW'(m[1:0]));
                check(cap_gid[0] == GW'(v) && cap_exp[0] == e, "R7 gid and hash kept",
                      {cap_gid[0], cap_exp[0]}, {GW'(v), e});
            end
        end
        check(cur_b == 2, "R2 wrap position", SW'(cur_b), SW'(2));

        // Full pool and mixed tags (R3, R4)
        begin
            int c0, c1;
            c0 = cur_b; c1 = (cur_b + 1) % NC;
            insert(c0, 10, 0, 32'h0, {4{32'hC0DE_0000 + 32'd10}});
            insert(c0, 11, 0, 32'h0, {4{32'hC0DE_0000 + 32'd11}});
            insert(c1, 12, 0, 32'h0, {4{32'hC0DE_0000 + 32'd12}});
            insert(c1, 13, 0, 32'h0, {4{32'hC0DE_0000 + 32'd13}});
            @(negedge clk);
            check(!ins_ready, "R3 full pool blocks", SW'(ins_ready), SW'(0));
            ins_valid = 1'b1; ins_chunk = 2'(c0); ins_gid = 8'd99; ins_cnt = '0; ins_sp = '1;
            @(posedge clk);
            #1 ins_valid = 1'b0;
            nf = 0; nd = 0;
            k = key_of(ncs);
            send_chunk();
            drain_count(n);
            check(n == 2, "R5 two issued", SW'(n), SW'(2));
            settle();
            ok = (nf == 2) && ((cap_gid[0] == 8'd10 && cap_gid[1] == 8'd11) ||
                               (cap_gid[0] == 8'd11 && cap_gid[1] == 8'd10));
            check(ok, "R4 only matching tags updated", SW'(nf), SW'(2));
            for (int i = 0; i < 2; i++)
                check(cap_sp[i] == mix_model({4{32'hC0DE_0000 + 32'(cap_gid[i])}}, k), "R6 per-entry mix",
                      cap_sp[i], mix_model({4{32'hC0DE_0000 + 32'(cap_gid[i])}}, k));
            check(ins_ready, "R3 slots freed", SW'(ins_ready), SW'(1));
            nf = 0; nd = 0;
            send_chunk();
            drain_count(n);
            check(n == 2, "R4 other tag kept waiting", SW'(n), SW'(2));
            settle();
            ok = (nf == 2) && (cap_gid[0] != 8'd99) && (cap_gid[1] != 8'd99);
            check(ok, "R3 dropped insert absent", SW'(nf), SW'(2));
        end

        // Insert after a pass started waits for the next pass (R10)
        tag = cur_b;
        insert(tag, 20, 0, 32'h0, {4{32'h0000_0020}});
        nf = 0; nd = 0;
        k = key_of(ncs);
        s21 = {4{32'h0000_0021}};
        send_chunk();
        insert(tag, 21, 0, 32'h0, s21);
        settle();
        check(nf == 1 && cap_gid[0] == 8'd20, "R10 late insert deferred", SW'(nf), SW'(1));
        check(cap_sp[0] == mix_model({4{32'h0000_0020}}, k), "R6 first pass key",
              cap_sp[0], mix_model({4{32'h0000_0020}}, k));
        nf = 0; nd = 0;
        k = key_of(ncs + NC - 1);
        for (int s = 0; s < NC; s++) send_chunk();
        settle();
        check(nf == 1 && cap_gid[0] == 8'd21, "R10 picked on next pass", SW'(nf), SW'(1));
        check(cap_sp[0] == mix_model(s21, k), "R10 later pass key", cap_sp[0], mix_model(s21, k));
        check(nd == 0, "R9 no stray retire", SW'(nd), SW'(0));

        finish_run();
    end
endmodule